// File: doc/BRIEF.md
# E1 Time Slot 16 Signaling Inserter

This block sits in the transmit path of an E1 framer and places channel-associated signaling into time slot 16. A host writes sixteen signaling bytes into a transmit buffer. At the start of every transmit multiframe, the whole buffer is copied into a snapshot bank. During that multiframe, each frame's time slot 16 is sourced from the snapshot entry that the frame index selects. The host therefore has one full multiframe (2 ms) to prepare the next set of bytes without tearing the set currently on the line.

The outgoing stream arrives one time slot (one byte) per clock cycle, together with its frame index (0 to 15) and slot index (0 to 31). A strobe marks slot 0 of frame 0. An enable input decides whether slot 16 is replaced or passed through. One cycle after each multiframe start, the block raises a single-cycle interrupt so the host knows when to refresh the buffer. A read port returns the buffer contents. The block does not generate the multiframe alignment nibble: the host writes it into the byte for frame 0.

Top module: `e1_cas_tx_inserter`

## Requirements
- R1: With insertion disabled, the byte presented in slot 16 leaves the block unchanged.
- R2: With insertion enabled, slot 16 of frame k carries snapshot byte k (buffer address k), bit 7 first on the line. Frames 1 to 15 carry channel k in bits 7..4 and channel k+15 in bits 3..0.
- R3: Every slot other than 16 passes through unchanged, whatever the enable state.
- R4: A host write stores the byte at its address (0 to 15) in the transmit buffer. The read port returns that byte at the following clock.
- R5: The snapshot is loaded only in the multiframe-start cycle. A write made later in a multiframe first appears on the line in the next multiframe.
- R6: A write in the same cycle as the multiframe-start strobe is not part of that snapshot and takes effect one multiframe later.
- R7: Buffer entries the host does not rewrite keep their contents and are sent again unchanged in every following multiframe.
- R8: The interrupt output is high for exactly the cycle after each multiframe-start strobe and low otherwise.
- R9: Synchronous reset clears the buffer, the snapshot and the registered enable, and drives the data output and the interrupt low.
- R10: The data output is registered: the byte presented in one cycle appears at the output after the next rising clock edge.
- R11: Frame 0 carries buffer address 0 exactly as written, with no alignment pattern forced into its upper nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ins_en | input | 1 | Slot 16 insertion enable |
| mf_start | input | 1 | Strobe on slot 0 of frame 0 |
| frame_idx | input | 4 | Frame number within the multiframe |
| slot_idx | input | 5 | Time slot number within the frame |
| tx_data_in | input | 8 | Outgoing slot byte before insertion |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | 4 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 4 | Host read address |
| host_rdata | output | 8 | Transmit buffer contents at host_raddr |
| tx_data_out | output | 8 | Outgoing slot byte after insertion |
| mf_irq | output | 1 | Multiframe refresh pulse |

## Verification
The assertions check these properties on every cycle: non-signaling slots pass through with one cycle of latency, slot 16 passes through when insertion is disabled, the snapshot never changes outside a load cycle, the buffer never changes without a write, and the interrupt follows the strobe. Only the bench scenarios can show that a write lands in the right multiframe (mid-multiframe, or in the same cycle as the strobe), that each frame carries the correct byte, that untouched bytes repeat, and that reset empties both storage stages.

// File: rtl/e1_sig_pkg.sv
package e1_sig_pkg;
    localparam int SIG_FRAMES = 16;
    localparam int SIG_BYTE_W = 8;
    localparam int SIG_SLOTS  = 32;
    localparam int SIG_SLOT   = 16;
    localparam int FRM_W      = $clog2(SIG_FRAMES);
    localparam int SLOT_W     = $clog2(SIG_SLOTS);

    typedef logic [SIG_BYTE_W-1:0] sig_byte_t;

    typedef struct packed {
        logic [FRM_W-1:0]  frame;
        logic [SLOT_W-1:0] slot;
        sig_byte_t         data;
    } slot_beat_t;

    typedef struct packed {
        logic             wr;
        logic [FRM_W-1:0] addr;
        sig_byte_t        data;
    } host_wr_t;

    function automatic logic is_sig_slot(input logic [SLOT_W-1:0] slot);
        return slot == SLOT_W'(SIG_SLOT);
    endfunction
endpackage

// File: rtl/e1_sig_txbuf.sv
module e1_sig_txbuf
    import e1_sig_pkg::*;
#(
    parameter int N = SIG_FRAMES,
    parameter int W = SIG_BYTE_W,
    localparam int AW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  host_wr_t       wr,
    input  logic [AW-1:0]  rd_addr,
    output logic [W-1:0]   rd_data,
    output logic [N*W-1:0] bank_flat
);
    logic [W-1:0] mem [N];

    for (genvar i = 0; i < N; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (wr.wr && wr.addr == AW'(i))
                mem[i] <= wr.data;
        end
        assign bank_flat[i*W +: W] = mem[i];
    end

    assign rd_data = mem[rd_addr];

    // R7: contents only change through a host write
    assert_buf_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wr.wr |=> $stable(bank_flat));
    // R4: a written byte is readable at the written address
    assert_buf_store_R4: assert property (@(posedge clk) disable iff (rst)
        (wr.wr && wr.addr == rd_addr) |=> (rd_data == $past(wr.data) || $past(rd_addr) != rd_addr));
endmodule

// File: rtl/e1_sig_snap.sv
module e1_sig_snap
    import e1_sig_pkg::*;
#(
    parameter int N = SIG_FRAMES,
    parameter int W = SIG_BYTE_W,
    localparam int AW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [N*W-1:0] bank_flat,
    input  logic [AW-1:0]  sel,
    output logic [W-1:0]   sel_byte
);
    logic [W-1:0]   snap [N];
    logic [N*W-1:0] snap_flat;

    for (genvar i = 0; i < N; i++) begin : g_snap
        always_ff @(posedge clk) begin
            if (rst)
                snap[i] <= '0;
            else if (load)
                snap[i] <= bank_flat[i*W +: W];
        end
        assign snap_flat[i*W +: W] = snap[i];
    end

    assign sel_byte = snap[sel];

    // R5: snapshot frozen between multiframe loads
    assert_snap_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(snap_flat));
    // R6: a load captures the buffer as it stood before that edge
    assert_snap_capture_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> snap_flat == $past(bank_flat));
endmodule

// File: rtl/e1_ts16_mux.sv
module e1_ts16_mux
    import e1_sig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_in,
    input  slot_beat_t beat,
    input  sig_byte_t  sig_byte,
    output sig_byte_t  data_out
);
    logic en_q;
    logic take_sig;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= en_in;
    end

    assign take_sig = en_q && is_sig_slot(beat.slot);

    always_ff @(posedge clk) begin
        if (rst)
            data_out <= '0;
        else if (take_sig)
            data_out <= sig_byte;
        else
            data_out <= beat.data;
    end

    // R1: disabled insertion leaves slot 16 untouched
    assert_ts16_bypass_R1: assert property (@(posedge clk) disable iff (rst)
        (!en_q && is_sig_slot(beat.slot)) |=> data_out == $past(beat.data));
    // R3 and R10: other slots pass with one cycle of latency
    assert_other_slots_R3: assert property (@(posedge clk) disable iff (rst)
        !is_sig_slot(beat.slot) |=> data_out == $past(beat.data));
endmodule

// File: rtl/e1_cas_tx_inserter.sv
module e1_cas_tx_inserter
    import e1_sig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_en,
    input  logic              mf_start,
    input  logic [FRM_W-1:0]  frame_idx,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [7:0]        tx_data_in,
    input  logic              host_wr,
    input  logic [FRM_W-1:0]  host_waddr,
    input  logic [7:0]        host_wdata,
    input  logic [FRM_W-1:0]  host_raddr,
    output logic [7:0]        host_rdata,
    output logic [7:0]        tx_data_out,
    output logic              mf_irq
);
    localparam int BANK_W = SIG_FRAMES * SIG_BYTE_W;

    host_wr_t          hw;
    slot_beat_t        beat;
    logic [BANK_W-1:0] bank;
    sig_byte_t         cur_sig;

    assign hw   = '{wr: host_wr, addr: host_waddr, data: host_wdata};
    assign beat = '{frame: frame_idx, slot: slot_idx, data: tx_data_in};

    e1_sig_txbuf #(.N(SIG_FRAMES), .W(SIG_BYTE_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr        (hw),
        .rd_addr   (host_raddr),
        .rd_data   (host_rdata),
        .bank_flat (bank)
    );

    e1_sig_snap #(.N(SIG_FRAMES), .W(SIG_BYTE_W)) u_snap (
        .clk       (clk),
        .rst       (rst),
        .load      (mf_start),
        .bank_flat (bank),
        .sel       (frame_idx),
        .sel_byte  (cur_sig)
    );

    e1_ts16_mux u_mux (
        .clk      (clk),
        .rst      (rst),
        .en_in    (ins_en),
        .beat     (beat),
        .sig_byte (cur_sig),
        .data_out (tx_data_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mf_irq <= 1'b0;
        else
            mf_irq <= mf_start;
    end

    // R8: pulse follows the strobe and nothing else
    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
        mf_start |=> mf_irq);
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        mf_irq |-> $past(mf_start));
    // R9: reset empties the outputs
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (tx_data_out == 8'h00 && !mf_irq));
endmodule

// File: tb/test_e1_cas_tx_inserter.sv
`timescale 1ns/1ps
module test_e1_cas_tx_inserter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ins_en = 1'b0;
    logic       mf_start = 1'b0;
    logic [3:0] frame_idx = '0;
    logic [4:0] slot_idx = '0;
    logic [7:0] tx_data_in = '0;
    logic       host_wr = 1'b0;
    logic [3:0] host_waddr = '0;
    logic [7:0] host_wdata = '0;
    logic [3:0] host_raddr = '0;
    logic [7:0] host_rdata;
    logic [7:0] tx_data_out;
    logic       mf_irq;

    int checks = 0;
    int errors = 0;

    // stimulus table: bytes written to addresses 0..15, address 0 has a
    // nonzero upper nibble on purpose (R11)
    localparam logic [7:0] WR_TAB [16] = '{
        8'hA5, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE,
        8'hF0, 8'h0F, 8'h1E, 8'h2D, 8'h3C, 8'h4B, 8'h5A, 8'h69};

    logic [7:0] mbuf [16];
    logic [7:0] msnap [16];
    logic       men_q;
    logic [7:0] obs [16];

    // scheduled host writes
    int         n_wr;
    logic [3:0] wr_f [8];
    logic [4:0] wr_s [8];
    logic [3:0] wr_a [8];
    logic [7:0] wr_d [8];

    always #2 clk = ~clk;

    e1_cas_tx_inserter i_e1_cas_tx_inserter (
        .clk(clk), .rst(rst), .ins_en(ins_en), .mf_start(mf_start),
        .frame_idx(frame_idx), .slot_idx(slot_idx), .tx_data_in(tx_data_in),
        .host_wr(host_wr), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .tx_data_out(tx_data_out), .mf_irq(mf_irq));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 16; i++) begin
            mbuf[i] = '0;
            msnap[i] = '0;
        end
        men_q = 1'b0;
    endtask

    // one slot of the stream; inputs driven 1 ns after an edge, output
    // sampled 1 ns after the next edge (one register, R10)
    task automatic cycle(input int f, input int s, input logic en);
        logic [7:0] din, exp_out;
        logic       mf, w;
        logic [3:0] wa;
        logic [7:0] wd;
        din = 8'((s * 7) + (f * 13) + 5);
        mf = (f == 0 && s == 0);
        w = 1'b0; wa = '0; wd = '0;
        for (int k = 0; k < n_wr; k++)
            if (wr_f[k] == 4'(f) && wr_s[k] == 5'(s)) begin
                w = 1'b1; wa = wr_a[k]; wd = wr_d[k];
            end
        ins_en = en; mf_start = mf; frame_idx = 4'(f); slot_idx = 5'(s);
        tx_data_in = din; host_wr = w; host_waddr = wa; host_wdata = wd;
        exp_out = (men_q && s == 16) ? msnap[f] : din;
        if (mf) for (int i = 0; i < 16; i++) msnap[i] = mbuf[i];
        if (w) mbuf[wa] = wd;
        men_q = en;
        @(posedge clk); #1;
        if (s == 16) begin
            obs[f] = tx_data_out;
            if (en) check("R2", tx_data_out, exp_out);
            else    check("R1", tx_data_out, exp_out);
        end else begin
            check("R3 R10", tx_data_out, exp_out);
        end
        check("R8", {7'd0, mf_irq}, {7'd0, mf});
    endtask

    task automatic run_mf(input logic en);
        for (int f = 0; f < 16; f++)
            for (int s = 0; s < 32; s++)
                cycle(f, s, en);
        n_wr = 0;
    endtask

    task automatic readback_all(input string req);
        for (int a = 0; a < 16; a++) begin
            host_raddr = 4'(a);
            #0.2;
            check(req, host_rdata, mbuf[a]);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        host_wr = 1'b0; mf_start = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        model_clear();
        check("R9", tx_data_out, 8'h00);
        check("R9", {7'd0, mf_irq}, 8'h00);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        n_wr = 0;
        model_clear();
        do_reset();
        readback_all("R9");

        // load the table while insertion is off; slot 16 passes (R1)
        for (int k = 0; k < 8; k++) begin
            wr_f[k] = 4'(2); wr_s[k] = 5'(k + 3);
            wr_a[k] = 4'(k); wr_d[k] = WR_TAB[k];
        end
        n_wr = 8;
        run_mf(1'b0);
        for (int k = 0; k < 8; k++) begin
            wr_f[k] = 4'(5); wr_s[k] = 5'(k + 20);
            wr_a[k] = 4'(k + 8); wr_d[k] = WR_TAB[k + 8];
        end
        n_wr = 8;
        run_mf(1'b0);
        readback_all("R4");

        // insertion on: every frame carries its table byte (R2, R11)
        run_mf(1'b1);
        for (int f = 0; f < 16; f++) check("R2", obs[f], WR_TAB[f]);
        check("R11", obs[0], 8'hA5);

        // mid-multiframe write to 3, coincident write to 9
        wr_f[0] = 4'(1); wr_s[0] = 5'(4); wr_a[0] = 4'(3); wr_d[0] = 8'hC3;
        wr_f[1] = 4'(0); wr_s[1] = 5'(0); wr_a[1] = 4'(9); wr_d[1] = 8'h99;
        n_wr = 2;
        run_mf(1'b1);
        check("R5", obs[3], WR_TAB[3]);
        check("R6", obs[9], WR_TAB[9]);
        host_raddr = 4'(3); #0.2; check("R4", host_rdata, 8'hC3);

        run_mf(1'b1);
        check("R5", obs[3], 8'hC3);
        check("R6", obs[9], 8'h99);
        for (int f = 0; f < 16; f++)
            if (f != 3 && f != 9) check("R7", obs[f], WR_TAB[f]);

        // reset in the middle of a stream empties buffer and snapshot
        for (int s = 0; s < 10; s++) cycle(0, s, 1'b1);
        do_reset();
        readback_all("R9");
        run_mf(1'b1);
        run_mf(1'b1);
        for (int f = 0; f < 16; f++) check("R9", obs[f], 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule